// File: doc/BRIEF.md
# Condition Flag and Branch Resolution Unit

This block holds the processor's three sign flags (negative, zero, positive) and resolves conditional branches. Whenever the register file accepts a 16-bit result, the unit classifies that result as a two's complement number and records its sign class in the flag register on the next clock edge. Stores, branches and idle cycles leave the flags alone, so at any moment the flags describe the most recent register-writing result.

When a branch is evaluated, the instruction supplies a 3-bit mask that selects which flags it cares about. The branch is taken when any selected flag is set. On a taken branch the next PC is the already-incremented PC plus a sign-extended 9-bit offset, which lets a branch reach roughly 256 words either way. On an untaken branch, or when no branch is being evaluated, the next PC is the incremented PC unchanged. The taken signal and next PC are combinational from the current flags and the branch inputs.

Top module: `branch_flag_unit`

## Requirements
- R1: After reset the flags read 3'b010 (zero set). Flag bit 2 is negative, bit 1 is zero, bit 0 is positive.
- R2: When `wbValid` is high at a rising clock edge, the flags after that edge are 3'b100 if `wbData[15]` is 1, 3'b010 if `wbData` is all zeros, and 3'b001 otherwise.
- R3: Exactly one flag bit is set at every cycle after reset.
- R4: When `wbValid` is low at a clock edge, the flags keep their value, whatever the branch inputs do.
- R5: `brTaken` is 1 exactly when `brEval` is high and at least one mask bit is set whose flag is set (mask bit 2 tests negative, bit 1 zero, bit 0 positive).
- R6: When `brTaken` is 1, `nextPc` equals `pcInc` plus `brOffset` sign-extended from bit 8, modulo 2^16.
- R7: When `brTaken` is 0, including when `brEval` is low, `nextPc` equals `pcInc`.
- R8: A mask of 3'b000 never takes the branch and a mask of 3'b111 always takes it while `brEval` is high.
- R9: A branch evaluated in the same cycle as a write-back uses the flags held before that write-back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wbValid | input | 1 | Register file write strobe |
| wbData | input | 16 | Value being written to the register file |
| brEval | input | 1 | Conditional branch is being evaluated |
| brMask | input | 3 | Flag selection mask from the instruction |
| brOffset | input | 9 | Signed PC offset from the instruction |
| pcInc | input | 16 | PC already incremented past the branch |
| flags | output | 3 | Current flags {negative, zero, positive} |
| brTaken | output | 1 | Branch is taken this cycle |
| nextPc | output | 16 | PC for the next fetch |

## Verification
The case hardest to reach from the ports is the overlap of a write-back and a branch evaluation in one cycle, where the branch must see the old flags while the register is about to change. The stimulus sets up a zero result, then presents a positive write-back together with a zero-testing branch, sampling the taken signal before the edge and the flags and taken signal after it. Offsets at both ends of the 9-bit range and a PC that wraps past 16'hFFFF cover the target arithmetic.

// File: rtl/bfu_pkg.sv
package bfu_pkg;
  localparam int FLAG_W = 3;
  localparam logic [FLAG_W-1:0] FLAG_NEG  = 3'b100;
  localparam logic [FLAG_W-1:0] FLAG_ZERO = 3'b010;
  localparam logic [FLAG_W-1:0] FLAG_POS  = 3'b001;

  typedef struct packed {
    logic loadFlags;
    logic redirect;
  } bfuStrobe_t;
endpackage

// File: rtl/bfu_ctrl.sv
module bfu_ctrl
  import bfu_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wbValid,
  input  logic              brEval,
  input  logic [FLAG_W-1:0] brMask,
  input  logic [FLAG_W-1:0] curFlags,
  output bfuStrobe_t        strobe
);
  logic maskHit;

  always_comb begin
    maskHit          = |(brMask & curFlags);
    strobe.loadFlags = wbValid;
    strobe.redirect  = brEval & maskHit;
  end

  // R8: an empty mask never redirects
  a_r8_mask_none: assert property (@(posedge clk) disable iff (!rstN)
    (brEval && brMask == '0) |-> !strobe.redirect);
  // R8: a full mask always redirects given one-hot flags from the datapath
  a_r8_mask_all: assert property (@(posedge clk) disable iff (!rstN)
    (brEval && brMask == '1) |-> strobe.redirect);
endmodule

// File: rtl/bfu_datapath.sv
module bfu_datapath
  import bfu_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int OFF_W  = 9
) (
  input  logic              clk,
  input  logic              rstN,
  input  bfuStrobe_t        strobe,
  input  logic [DATA_W-1:0] wbData,
  input  logic [OFF_W-1:0]  brOffset,
  input  logic [DATA_W-1:0] pcInc,
  output logic [FLAG_W-1:0] flags,
  output logic [DATA_W-1:0] nextPc
);
  localparam int EXT_W = DATA_W - OFF_W;

  logic [FLAG_W-1:0] flagQ;
  logic [FLAG_W-1:0] flagNext;
  logic [DATA_W-1:0] offExt;

  always_comb begin
    if (wbData[DATA_W-1])  flagNext = FLAG_NEG;
    else if (wbData == '0) flagNext = FLAG_ZERO;
    else                   flagNext = FLAG_POS;
  end

  always_ff @(posedge clk) begin
    if (!rstN)                 flagQ <= FLAG_ZERO;
    else if (strobe.loadFlags) flagQ <= flagNext;
  end

  always_comb begin
    offExt = {{EXT_W{brOffset[OFF_W-1]}}, brOffset};
    nextPc = strobe.redirect ? (pcInc + offExt) : pcInc;
  end

  assign flags = flagQ;

  // R3: flags stay one-hot
  a_r3_onehot: assert property (@(posedge clk) disable iff (!rstN)
    $countones(flagQ) == 1);
  // R4: no write-back, no flag change
  a_r4_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.loadFlags |=> $stable(flagQ));
  // R2: negative result
  a_r2_neg: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.loadFlags && wbData[DATA_W-1]) |=> flagQ == FLAG_NEG);
  // R2: zero result
  a_r2_zero: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.loadFlags && wbData == '0) |=> flagQ == FLAG_ZERO);
  // R7: no redirect keeps sequential PC
  a_r7_seq: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.redirect |-> nextPc == pcInc);
endmodule

// File: rtl/branch_flag_unit.sv
module branch_flag_unit
  import bfu_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int OFF_W  = 9
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wbValid,
  input  logic [DATA_W-1:0] wbData,
  input  logic              brEval,
  input  logic [FLAG_W-1:0] brMask,
  input  logic [OFF_W-1:0]  brOffset,
  input  logic [DATA_W-1:0] pcInc,
  output logic [FLAG_W-1:0] flags,
  output logic              brTaken,
  output logic [DATA_W-1:0] nextPc
);
  bfuStrobe_t strobe;

  bfu_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .wbValid(wbValid), .brEval(brEval),
    .brMask(brMask), .curFlags(flags), .strobe(strobe)
  );

  bfu_datapath #(.DATA_W(DATA_W), .OFF_W(OFF_W)) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wbData(wbData),
    .brOffset(brOffset), .pcInc(pcInc), .flags(flags), .nextPc(nextPc)
  );

  assign brTaken = strobe.redirect;
endmodule

// File: tb/branch_flag_unit_tb.sv
module branch_flag_unit_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wbValid = 1'b0;
  logic [15:0] wbData = '0;
  logic        brEval = 1'b0;
  logic [2:0]  brMask = '0;
  logic [8:0]  brOffset = '0;
  logic [15:0] pcInc = '0;
  logic [2:0]  flags;
  logic        brTaken;
  logic [15:0] nextPc;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #10 clk = ~clk;

  branch_flag_unit dut_i (
    .clk(clk), .rstN(rstN), .wbValid(wbValid), .wbData(wbData),
    .brEval(brEval), .brMask(brMask), .brOffset(brOffset), .pcInc(pcInc),
    .flags(flags), .brTaken(brTaken), .nextPc(nextPc)
  );

  // {wbData, mask, offset, pcInc, expFlags, expTaken, expNext}
  typedef struct packed {
    logic [15:0] data;
    logic [2:0]  mask;
    logic [8:0]  off;
    logic [15:0] pc;
    logic [2:0]  expFlags;
    logic        expTaken;
    logic [15:0] expNext;
  } vec_t;

  localparam int NVEC = 7;
  localparam vec_t VECS [NVEC] = '{
    '{16'h8000, 3'b100, 9'h005, 16'h3000, 3'b100, 1'b1, 16'h3005},
    '{16'h0000, 3'b010, 9'h1FA, 16'h3004, 3'b010, 1'b1, 16'h2FFE},
    '{16'h0001, 3'b001, 9'h0FF, 16'h3000, 3'b001, 1'b1, 16'h30FF},
    '{16'h7FFF, 3'b110, 9'h010, 16'h4000, 3'b001, 1'b0, 16'h4000},
    '{16'hFFFF, 3'b011, 9'h100, 16'h4000, 3'b100, 1'b0, 16'h4000},
    '{16'hFFFF, 3'b101, 9'h100, 16'h4100, 3'b100, 1'b1, 16'h4000},
    '{16'h0000, 3'b010, 9'h002, 16'hFFFF, 3'b010, 1'b1, 16'h0001}
  };

  task automatic check(input logic ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      nFails++; nChecks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(flags == 3'b010, "R1 reset flags", flags, 3'b010);
    pcInc = 16'h1234; brMask = 3'b111; brOffset = 9'h020;
    #1;
    // R7 no evaluation keeps PC
    check(!brTaken, "R7 idle taken", brTaken, 0);
    check(nextPc == 16'h1234, "R7 idle nextPc", nextPc, 16'h1234);

    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk);
      wbValid = 1'b1; wbData = VECS[i].data; brEval = 1'b0;
      @(negedge clk);
      wbValid = 1'b0;
      check(flags == VECS[i].expFlags, "R2 classify", flags, VECS[i].expFlags);
      check($countones(flags) == 1, "R3 one-hot", flags, 1);
      brEval = 1'b1; brMask = VECS[i].mask; brOffset = VECS[i].off;
      pcInc = VECS[i].pc;
      #1;
      check(brTaken == VECS[i].expTaken, "R5 taken", brTaken, VECS[i].expTaken);
      check(nextPc == VECS[i].expNext, "R6/R7 nextPc", nextPc, VECS[i].expNext);
      @(negedge clk);
      check(flags == VECS[i].expFlags, "R4 hold under branch", flags,
            VECS[i].expFlags);
      brEval = 1'b0;
    end

    // R8: masks 000 and 111 against each flag value
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      wbValid = 1'b1;
      wbData = (k == 0) ? 16'h8001 : ((k == 1) ? 16'h0000 : 16'h0042);
      @(negedge clk);
      wbValid = 1'b0; brEval = 1'b1; brOffset = 9'h004; pcInc = 16'h0100;
      brMask = 3'b000;
      #1;
      check(!brTaken, "R8 mask none", brTaken, 0);
      check(nextPc == 16'h0100, "R8 mask none pc", nextPc, 16'h0100);
      brMask = 3'b111;
      #1;
      check(brTaken, "R8 mask all", brTaken, 1);
      check(nextPc == 16'h0104, "R8 mask all pc", nextPc, 16'h0104);
      brEval = 1'b0;
    end

    // R9: flags are positive now; set zero, then overlap write and branch
    @(negedge clk);
    wbValid = 1'b1; wbData = 16'h0000;
    @(negedge clk);
    wbData = 16'h0001; brEval = 1'b1; brMask = 3'b010;
    brOffset = 9'h008; pcInc = 16'h2000;
    #1;
    check(brTaken, "R9 old flags used", brTaken, 1);
    check(nextPc == 16'h2008, "R9 old flags pc", nextPc, 16'h2008);
    @(negedge clk);
    wbValid = 1'b0;
    check(flags == 3'b001, "R9 flags after write", flags, 3'b001);
    #1;
    check(!brTaken, "R9 new flags used", brTaken, 0);
    brEval = 1'b0;

    // R4: idle cycles keep flags
    repeat (3) @(negedge clk);
    check(flags == 3'b001, "R4 idle hold", flags, 3'b001);

    // R1: reset mid-run restores zero flag
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    check(flags == 3'b010, "R1 re-reset", flags, 3'b010);

    done = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule